// File: doc/BRIEF.md
# Clock-Generator Configuration Serial Slave

This block is the configuration front end of a clock-generator control core. It sits on a two-wire serial bus as a slave with 7-bit address 0x69. It holds a small bank of byte-wide registers and presents their contents as parallel control vectors: a 5-bit frequency code, a select-override flag, a spread-spectrum enable, a tristate request, and one enable bit for each clock output.

The bus supports only block transfers that always start at register 0. A write carries a command byte and a count byte. Both are acknowledged and then thrown away, and the data bytes that follow fill the registers in ascending order. A read returns a count byte first, then the registers from 0 upward. At the first clock after reset is released, the block samples five strap pins. Four of them give the frequency code used when the override is off, and all five are returned inverted in the last register.

SCL and SDA reach the block as plain inputs. The block drives SDA only through an active-high pull-low enable. Both lines pass through a two-flop synchronizer and a persistence filter, and the system clock must be at least ten times the bus bit rate.

Top module: `clkgen_cfg_i2c`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read). Any other address gets no acknowledge, and the transfer that follows changes nothing.
- R2: In a write, the first two bytes after the address (command and count) are acknowledged and their values ignored. The first data byte always lands in register 0.
- R3: Each following data byte goes to the next register up and is acknowledged on its own.
- R4: A STOP after any complete byte ends the write. Registers already written keep their new values, and all other registers keep their previous values.
- R5: A read returns the byte NUM_REGS first, then registers 0 to NUM_REGS-1 in order, each sent MSB first. Bytes past the end read as 0xFF.
- R6: After reset, register 0 is 0x00 and registers 1 to NUM_REGS-2 are 0xFF.
- R7: Register 0 is decoded as follows:
  - Bit 3 set: freq_code_o = {bit7, bit2, bit6, bit5, bit4} and freq_override_o is 1.
  - Bit 3 clear: freq_code_o = {0, strap[3:0]}.
  - Bit 1 drives spread_en_o.
  - Bit 0 drives tristate_o.
- R8: The straps are captured once, at the first clock edge after reset is released, and later changes are ignored. Register NUM_REGS-1 reads {000, ~strap[4:0]}.
- R9: Data bytes aimed at register NUM_REGS-1 or beyond are acknowledged and discarded.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and stays off the bus until the next START.
- R11: An SDA or SCL pulse lasting fewer than FILT_LEN system clocks has no effect, so a short low glitch during SCL high is not taken as a START.
- R12: Bits [8k+7:8k] of out_en_o hold register k+1, for k from 0 to NUM_REGS-3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 5 | Strap levels, [3:0] frequency select |
| freq_code_o | output | 5 | Effective frequency code |
| freq_override_o | output | 1 | Register-selected frequency active |
| spread_en_o | output | 1 | Spread spectrum enable |
| tristate_o | output | 1 | Tristate all clock outputs |
| out_en_o | output | 8*(NUM_REGS-2) | Per-output enables |

## Verification
The assertions check on every cycle that:
- SDA is driven only during acknowledge and transmit phases, and never while the slave is idle.
- Register writes target only the writable range.
- Register contents never change without a write strobe.
- The captured straps never move once taken.
- The filtered line levels change only to a level the synchronizer has settled on.

Only the bench scenarios can show the byte-level protocol behaviour: which bytes are acknowledged, how data and addresses map to registers, the discarding of command, count and overflow bytes, partial writes, the count-first read order, release after a host NACK, and glitch rejection in the middle of a transfer.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned FREQ_W  = 5;
  localparam int unsigned STRAP_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WRX,
    ST_WACK,
    ST_RTX,
    ST_RACK
  } bus_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN) + 1;

  logic [1:0]    sync_q;
  logic          out_q;
  logic [CW-1:0] cnt_q;

  // new level must persist FILT_LEN samples before it is accepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        out_q <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;

  a_r11_filter_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> ($past(sync_q[1]) == out_q));
endmodule

// File: rtl/i2c_block_engine.sv
module i2c_block_engine
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int unsigned AW = $clog2(NUM_REGS),
  localparam int unsigned IW = $clog2(NUM_REGS + 3)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i
);
  bus_state_e    st_q;
  logic          scl_d, sda_d;
  logic [3:0]    bcnt_q;
  logic [7:0]    sh_q;
  logic          rw_q;
  logic [IW-1:0] idx_q;
  logic          oe_q;

  logic start_det, stop_det, scl_rise, scl_fall;
  logic wr_hit, rd_hit, idx_sat;
  logic [7:0] tx_byte;

  assign start_det = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_det  = scl_i & scl_d & ~sda_d & sda_i;
  assign scl_rise  = scl_i & ~scl_d;
  assign scl_fall  = ~scl_i & scl_d;

  // write byte index: 0 cmd, 1 count, 2.. data for reg idx-2
  assign wr_hit  = (idx_q >= IW'(2)) && (idx_q < IW'(NUM_REGS + 1));
  // read byte index: 0 count, 1.. reg idx-1
  assign rd_hit  = (idx_q >= IW'(1)) && (idx_q < IW'(NUM_REGS + 1));
  assign idx_sat = (idx_q == IW'(NUM_REGS + 2));
  assign rd_addr_o = AW'(idx_q - IW'(1));

  always_comb begin
    if (idx_q == '0)  tx_byte = 8'(NUM_REGS);
    else if (rd_hit)  tx_byte = rd_data_i;
    else              tx_byte = 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      bcnt_q    <= '0;
      sh_q      <= '0;
      rw_q      <= 1'b0;
      idx_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      scl_d   <= scl_i;
      sda_d   <= sda_i;
      wr_en_o <= 1'b0;
      if (start_det) begin
        st_q   <= ST_ADDR;
        bcnt_q <= '0;
        idx_q  <= '0;
        oe_q   <= 1'b0;
      end else if (stop_det) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WRX: begin
            if (scl_rise) begin
              sh_q   <= {sh_q[6:0], sda_i};
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall && bcnt_q == 4'd8) begin
              bcnt_q <= '0;
              if (st_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                  st_q <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                oe_q <= 1'b1;
                st_q <= ST_WACK;
                if (wr_hit) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= AW'(idx_q - IW'(2));
                  wr_data_o <= sh_q;
                end
                if (!idx_sat) idx_q <= idx_q + 1'b1;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                sh_q   <= tx_byte;
                oe_q   <= ~tx_byte[7];
                bcnt_q <= 4'd1;
                idx_q  <= idx_q + 1'b1;
                st_q   <= ST_RTX;
              end else begin
                oe_q <= 1'b0;
                st_q <= ST_WRX;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              oe_q <= 1'b0;
              st_q <= ST_WRX;
            end
          end
          ST_RTX: begin
            if (scl_fall) begin
              if (bcnt_q == 4'd8) begin
                oe_q <= 1'b0;
                st_q <= ST_RACK;
              end else begin
                oe_q   <= ~sh_q[6];
                sh_q   <= {sh_q[6:0], 1'b0};
                bcnt_q <= bcnt_q + 1'b1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_i) begin
              st_q <= ST_IDLE;
            end else if (scl_fall) begin
              sh_q   <= tx_byte;
              oe_q   <= ~tx_byte[7];
              bcnt_q <= 4'd1;
              if (!idx_sat) idx_q <= idx_q + 1'b1;
              st_q   <= ST_RTX;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;

  a_r10_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  a_r5_drive_phases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (st_q inside {ST_AACK, ST_WACK, ST_RTX}));
  a_r9_wr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o < AW'(NUM_REGS - 1)));
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  localparam int unsigned AW  = $clog2(NUM_REGS),
  localparam int unsigned NWR = NUM_REGS - 1,
  localparam int unsigned ENW = 8 * (NUM_REGS - 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [7:0]         wr_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [FREQ_W-1:0]  freq_code_o,
  output logic               freq_override_o,
  output logic               spread_en_o,
  output logic               tristate_o,
  output logic [ENW-1:0]     out_en_o
);
  logic [NWR-1:0][7:0]   regs_q;
  logic [STRAP_W-1:0]    strap_q;
  logic                  strap_done_q;
  logic [7:0]            ctrl;

  for (genvar k = 0; k < NWR; k++) begin : g_reg
    localparam logic [7:0] RST_VAL = (k == 0) ? 8'h00 : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[k] <= RST_VAL;
      else if (wr_en_i && wr_addr_i == AW'(k))     regs_q[k] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_q      <= '0;
      strap_done_q <= 1'b0;
    end else if (!strap_done_q) begin
      strap_q      <= strap_i;
      strap_done_q <= 1'b1;
    end
  end

  always_comb begin
    if (rd_addr_i == AW'(NUM_REGS - 1)) rd_data_o = {{(8 - STRAP_W){1'b0}}, ~strap_q};
    else                                rd_data_o = regs_q[rd_addr_i];
  end

  assign ctrl            = regs_q[0];
  assign freq_override_o = ctrl[3];
  assign freq_code_o     = ctrl[3] ? {ctrl[7], ctrl[2], ctrl[6:4]} : {1'b0, strap_q[3:0]};
  assign spread_en_o     = ctrl[1];
  assign tristate_o      = ctrl[0];
  assign out_en_o        = regs_q[NWR-1:1];

  a_r4_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_q));
  a_r8_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_done_q && $past(strap_done_q)) |-> $stable(strap_q));
endmodule

// File: rtl/clkgen_cfg_i2c.sv
module clkgen_cfg_i2c
  import clkcfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 7,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned FILT_LEN = 3,
  localparam int unsigned AW  = $clog2(NUM_REGS),
  localparam int unsigned ENW = 8 * (NUM_REGS - 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [FREQ_W-1:0]  freq_code_o,
  output logic               freq_override_o,
  output logic               spread_en_o,
  output logic               tristate_o,
  output logic [ENW-1:0]     out_en_o
);
  logic [1:0]    raw_lines, filt_lines;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  assign raw_lines = {scl_i, sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (raw_lines[i]),
      .line_o (filt_lines[i])
    );
  end

  i2c_block_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt_lines[1]),
    .sda_i     (filt_lines[0]),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data)
  );

  cfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_en_i         (wr_en),
    .wr_addr_i       (wr_addr),
    .wr_data_i       (wr_data),
    .rd_addr_i       (rd_addr),
    .rd_data_o       (rd_data),
    .strap_i         (strap_i),
    .freq_code_o     (freq_code_o),
    .freq_override_o (freq_override_o),
    .spread_en_o     (spread_en_o),
    .tristate_o      (tristate_o),
    .out_en_o        (out_en_o)
  );
endmodule

// File: tb/tb_clkgen_cfg_i2c.sv
module tb_clkgen_cfg_i2c;
  localparam int NR  = 7;
  localparam int ENW = 8 * (NR - 2);
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [4:0] strap = 5'b10110;
  logic [4:0] freq_code;
  logic ovr, spread, tri_o;
  logic [ENW-1:0] out_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] tx_buf [0:15];
  logic [7:0] rx_buf [0:15];
  logic       ack_buf [0:15];
  logic [7:0] exp_reg [0:NR-1];
  bit glitch_en = 0;

  always #2 clk = ~clk;
  assign sda_line = host_sda & ~sda_oe;

  clkgen_cfg_i2c dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(strap), .freq_code_o(freq_code),
    .freq_override_o(ovr), .spread_en_o(spread), .tristate_o(tri_o),
    .out_en_o(out_en)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); host_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq(Q); scl = 1'b1;
      if (glitch_en && b[i]) begin
        wq(Q - 2); host_sda = 1'b0; wq(2); host_sda = 1'b1; wq(Q);
      end else begin
        wq(2 * Q);
      end
      scl = 1'b0; wq(Q);
    end
    host_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = ~sda_line; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic do_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    host_sda = ~do_ack; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    host_sda = 1'b1;
  endtask

  // address byte then n bytes from tx_buf; acks into ack_buf
  task automatic do_write(input logic [7:0] addr, input int n);
    logic a;
    bus_start();
    send_byte(addr, a); ack_buf[0] = a;
    for (int i = 0; i < n; i++) begin
      send_byte(tx_buf[i], a); ack_buf[i + 1] = a;
    end
    bus_stop();
    wq(Q);
  endtask

  task automatic do_read(input int n);
    logic a;
    bus_start();
    send_byte(8'hD3, a); ack_buf[0] = a;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rx_buf[i]);
    bus_stop();
    wq(Q);
  endtask

  function automatic logic [ENW-1:0] exp_en();
    logic [ENW-1:0] v;
    for (int k = 0; k < NR - 2; k++) v[8*k +: 8] = exp_reg[k + 1];
    return v;
  endfunction

  task automatic check_readback(input string req);
    do_read(NR + 1);
    chk({req, " R1 read addr ack"}, 64'(ack_buf[0]), 64'd1);
    chk({req, " R5 count first"}, 64'(rx_buf[0]), 64'(NR));
    for (int k = 0; k < NR; k++) chk({req, " R5 reg order"}, 64'(rx_buf[k + 1]), 64'(exp_reg[k]));
  endtask

  task automatic check_outputs(input string req, input logic [4:0] strap_cap);
    logic [7:0] c;
    c = exp_reg[0];
    chk({req, " R7 override"}, 64'(ovr), 64'(c[3]));
    chk({req, " R7 freq code"}, 64'(freq_code), 64'(c[3] ? {c[7], c[2], c[6:4]} : {1'b0, strap_cap[3:0]}));
    chk({req, " R7 spread"}, 64'(spread), 64'(c[1]));
    chk({req, " R7 tristate"}, 64'(tri_o), 64'(c[0]));
    chk({req, " R12 out_en map"}, 64'(out_en), 64'(exp_en()));
  endtask

  task automatic t_reset();
    exp_reg[0] = 8'h00;
    for (int k = 1; k < NR - 1; k++) exp_reg[k] = 8'hFF;
    exp_reg[NR - 1] = {3'b000, ~5'b10110};
    chk("R6 sda released at reset", 64'(sda_oe), 64'd0);
    check_outputs("R6 reset", 5'b10110);
    check_readback("R6 R8 reset readback");
  endtask

  task automatic t_full_write();
    tx_buf[0] = 8'h55; tx_buf[1] = 8'h03;
    tx_buf[2] = 8'hDB; tx_buf[3] = 8'hA5; tx_buf[4] = 8'h3C;
    tx_buf[5] = 8'h0F; tx_buf[6] = 8'hF0; tx_buf[7] = 8'h81;
    do_write(8'hD2, 8);
    for (int i = 0; i <= 8; i++) chk("R2 R3 write acks", 64'(ack_buf[i]), 64'd1);
    for (int k = 0; k < NR - 1; k++) exp_reg[k] = tx_buf[k + 2];
    check_outputs("R2 R3 full write", 5'b10110);
    chk("R7 override code value", 64'(freq_code), 64'(5'b10101));
    check_readback("R3 full write readback");
  endtask

  task automatic t_partial_write();
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h77;
    do_write(8'hD2, 4);
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h77;
    check_outputs("R4 partial write", 5'b10110);
    check_readback("R4 partial readback");
  endtask

  task automatic t_strap_change();
    strap = 5'b01001;
    wq(50);
    check_outputs("R8 strap ignored after capture", 5'b10110);
    check_readback("R8 strap readback");
  endtask

  task automatic t_wrong_addr();
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00; tx_buf[2] = 8'hFF; tx_buf[3] = 8'h00;
    do_write(8'hA0, 4);
    chk("R1 foreign address nack", 64'(ack_buf[0]), 64'd0);
    check_outputs("R1 foreign address no effect", 5'b10110);
  endtask

  task automatic t_overflow();
    tx_buf[0] = 8'hEE; tx_buf[1] = 8'h09;
    for (int k = 0; k < 9; k++) tx_buf[k + 2] = 8'h11 * 8'(k + 1);
    do_write(8'hD2, 11);
    for (int i = 0; i <= 11; i++) chk("R9 overflow acks", 64'(ack_buf[i]), 64'd1);
    for (int k = 0; k < NR - 1; k++) exp_reg[k] = tx_buf[k + 2];
    check_outputs("R9 overflow write", 5'b10110);
    check_readback("R9 last reg untouched");
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b1, b);
    chk("R5 count before data", 64'(b), 64'(NR));
    recv_byte(1'b0, b);
    chk("R5 reg0 after count", 64'(b), 64'(exp_reg[0]));
    for (int i = 0; i < 9; i++) begin
      wq(Q); scl = 1'b1; wq(Q);
      chk("R10 released after nack", 64'(sda_oe), 64'd0);
      wq(Q); scl = 1'b0; wq(Q);
    end
    bus_stop();
    wq(Q);
    check_readback("R10 read after nack");
  endtask

  task automatic t_glitch();
    tx_buf[0] = 8'h00; tx_buf[1] = 8'h00; tx_buf[2] = 8'h0A; tx_buf[3] = 8'hFF;
    bus_start();
    begin
      logic a;
      send_byte(8'hD2, a);
      send_byte(tx_buf[0], a);
      send_byte(tx_buf[1], a);
      glitch_en = 1;
      send_byte(tx_buf[2], a);
      glitch_en = 0;
      chk("R11 glitched byte acked", 64'(a), 64'd1);
      send_byte(tx_buf[3], a);
    end
    bus_stop();
    wq(Q);
    exp_reg[0] = 8'h0A; exp_reg[1] = 8'hFF;
    check_outputs("R11 glitch rejected", 5'b10110);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_full_write();
    t_partial_write();
    t_strap_change();
    t_wrong_addr();
    t_overflow();
    t_nack_release();
    t_glitch();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule